// File: doc/BRIEF.md
# Vector Instruction Sequencer with Local Word Memory

This block runs one vector instruction at a time against a small word-addressed memory that it owns. An instruction is presented together with a one-cycle start pulse. It names an operation, two source base addresses, a destination base address and an element count n. The engine steps through the element indices in ascending order, one element per clock. For each element it reads an operand pair from memory and applies the operation. It then either stores an element result or folds the value into a running scalar. When the instruction has finished, it pulses done.

The operations split into two classes. Element-wise operations write one result per element: add, multiply, AND, larger-of and the greater-than test. The vector-plus-scalar add also belongs here, and it takes its scalar from a single memory word. Reduction operations fold the first source vector into one scalar: sum and maximum. That scalar is written once, at the destination base address. A host port loads the memory and reads it back while the engine is idle.

Top module: `vec_engine`

## Requirements
- R1: After reset, busy and done are both 0.
- R2: start is taken only while busy is 0. From the edge that takes it, busy reads 1 up to and including the done cycle, then falls at the next edge. A start while busy has no effect on timing or memory.
- R3: done is a single-cycle pulse. For an element-wise operation with n > 0, it is high after the n-th edge following the edge that took start.
- R4: Opcode 0 writes dst[i] = s1[i] + s2[i], and opcode 1 writes dst[i] = s1[i] * s2[i]. Both keep the low DATA_W bits.
- R5: Opcode 2 writes the bitwise AND of the two elements. Opcode 3 writes the unsigned larger of the two.
- R6: Opcode 4 writes 1 when s1[i] > s2[i] (unsigned) and writes 0 otherwise, including when the two are equal.
- R7: Opcode 5 (sum modulo 2^DATA_W) and opcode 6 (unsigned maximum) reduce s1[0..n-1] to one scalar. The scalar is written only to the destination base, and done follows at the (n+1)-th edge.
- R8: Opcode 7 writes dst[i] = mem[src2 base] + s1[i]. The scalar is the single word at the source-2 base.
- R9: A count of 0 gives done right after the accepting edge and changes no memory word.
- R10: host_rdata shows mem[host_addr] combinationally. A host write while idle lands at the next edge. A host write while busy is ignored.
- R11: Element i uses address base+i modulo 2^ADDR_W. Elements run in ascending order, so a read sees the results of earlier elements of the same instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Instruction strobe |
| op_code | input | 3 | Operation select |
| src1_base | input | ADDR_W | First source base address |
| src2_base | input | ADDR_W | Second source base, or scalar address for opcode 7 |
| dst_base | input | ADDR_W | Destination base address |
| vec_len | input | ADDR_W+1 | Element count n |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| host_we | input | 1 | Host write enable |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Memory word at host_addr |

## Verification
Count edges from the one that takes start. done is due after edge 0 when the count is zero, after edge n for element-wise operations, and after edge n+1 for reductions. busy falls one edge later. The bench computes the due cycle from the opcode and the count before it issues start. It then samples busy and done at every falling edge up to that point and at one edge beyond it. Memory results are read through the combinational host port only after busy has fallen, and every word is compared against a sequential model that applies the instruction element by element.

// File: rtl/vec_pkg.sv
package vec_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_MUL  = 3'd1,
    OP_AND  = 3'd2,
    OP_LRG  = 3'd3,
    OP_TGT  = 3'd4,
    OP_SUM  = 3'd5,
    OP_MAX  = 3'd6,
    OP_SADD = 3'd7
  } vop_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RUN,
    S_RWR,
    S_DONE
  } vstate_e;
endpackage

// File: rtl/vec_mem.sv
module vec_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] ra_addr,
  input  logic [ADDR_W-1:0] rb_addr,
  input  logic [ADDR_W-1:0] rh_addr,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data,
  output logic [DATA_W-1:0] rh_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign ra_data = words[ra_addr];
  assign rb_data = words[rb_addr];
  assign rh_data = words[rh_addr];
endmodule

// File: rtl/vec_alu.sv
module vec_alu #(
  parameter int DATA_W = 16
) (
  input  vec_pkg::vop_e     op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] acc,
  input  logic              first,
  output logic [DATA_W-1:0] elem_res,
  output logic [DATA_W-1:0] red_res
);
  import vec_pkg::*;

  function automatic logic [DATA_W-1:0] f_elem(vop_e o, logic [DATA_W-1:0] x,
                                                logic [DATA_W-1:0] y);
    logic [DATA_W-1:0] r;
    case (o)
      OP_MUL:  r = x * y;
      OP_AND:  r = x & y;
      OP_LRG:  r = (x > y) ? x : y;
      OP_TGT:  r = (x > y) ? DATA_W'(1) : '0;
      default: r = x + y;
    endcase
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] f_fold(vop_e o, logic [DATA_W-1:0] s,
                                                logic [DATA_W-1:0] x, logic f);
    logic [DATA_W-1:0] r;
    if (f)            r = x;
    else if (o == OP_MAX) r = (x > s) ? x : s;
    else              r = s + x;
    return r;
  endfunction

  assign elem_res = f_elem(op, a, b);
  assign red_res  = f_fold(op, acc, a, first);
endmodule

// File: rtl/vec_seq.sv
module vec_seq #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  vec_pkg::vop_e     op_in,
  input  logic [ADDR_W-1:0] s1_in,
  input  logic [ADDR_W-1:0] s2_in,
  input  logic [ADDR_W-1:0] d_in,
  input  logic [LEN_W-1:0]  len_in,
  input  logic [DATA_W-1:0] elem_res,
  input  logic [DATA_W-1:0] red_res,
  output vec_pkg::vop_e     op_q,
  output logic [DATA_W-1:0] acc_q,
  output logic              first,
  output logic [ADDR_W-1:0] ra_addr,
  output logic [ADDR_W-1:0] rb_addr,
  output logic              eng_we,
  output logic [ADDR_W-1:0] eng_waddr,
  output logic [DATA_W-1:0] eng_wdata,
  output logic              busy,
  output logic              done
);
  import vec_pkg::*;

  vstate_e           state;
  logic [ADDR_W-1:0] s1_q, s2_q, d_q;
  logic [LEN_W-1:0]  len_q, idx_q;
  logic [ADDR_W-1:0] idx_a;
  logic              is_red, is_sadd;
  logic              ev_accept, ev_last, ev_red_wr;

  assign idx_a     = idx_q[ADDR_W-1:0];
  assign is_red    = (op_q == OP_SUM) || (op_q == OP_MAX);
  assign is_sadd   = (op_q == OP_SADD);
  assign ev_accept = (state == S_IDLE) && start;
  assign ev_last   = (state == S_RUN) && (idx_q == len_q - LEN_W'(1));
  assign ev_red_wr = (state == S_RWR);
  assign first     = (idx_q == '0);

  assign ra_addr   = s1_q + idx_a;
  assign rb_addr   = is_sadd ? s2_q : s2_q + idx_a;

  assign eng_we    = ((state == S_RUN) && !is_red) || ev_red_wr;
  assign eng_waddr = ev_red_wr ? d_q : d_q + idx_a;
  assign eng_wdata = ev_red_wr ? acc_q : elem_res;

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op_q  <= OP_ADD;
      s1_q  <= '0;
      s2_q  <= '0;
      d_q   <= '0;
      len_q <= '0;
      idx_q <= '0;
      acc_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          op_q  <= op_in;
          s1_q  <= s1_in;
          s2_q  <= s2_in;
          d_q   <= d_in;
          len_q <= len_in;
          idx_q <= '0;
          state <= (len_in == '0) ? S_DONE : S_RUN;
        end
        S_RUN: begin
          if (is_red) acc_q <= red_res;
          idx_q <= idx_q + LEN_W'(1);
          if (ev_last) state <= is_red ? S_RWR : S_DONE;
        end
        S_RWR:   state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy);
  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && (len_in == '0)) |=> done);
  // R3
  elem_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_last && !is_red) |=> done);
  // R7
  red_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_red_wr |=> done);
endmodule

// File: rtl/vec_engine.sv
module vec_engine #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  localparam int LEN_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op_code,
  input  logic [ADDR_W-1:0] src1_base,
  input  logic [ADDR_W-1:0] src2_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [LEN_W-1:0]  vec_len,
  output logic              busy,
  output logic              done,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata
);
  import vec_pkg::*;

  vop_e              op_q;
  logic [DATA_W-1:0] acc_q, elem_res, red_res, ra_data, rb_data, wdata;
  logic [ADDR_W-1:0] ra_addr, rb_addr, eng_waddr, waddr;
  logic              first, eng_we, host_ok, mem_we;
  logic [DATA_W-1:0] eng_wdata;

  assign host_ok = host_we && !busy;
  assign mem_we  = eng_we || host_ok;
  assign waddr   = eng_we ? eng_waddr : host_addr;
  assign wdata   = eng_we ? eng_wdata : host_wdata;

  vec_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(vop_e'(op_code)),
    .s1_in(src1_base), .s2_in(src2_base), .d_in(dst_base), .len_in(vec_len),
    .elem_res(elem_res), .red_res(red_res), .op_q(op_q), .acc_q(acc_q),
    .first(first), .ra_addr(ra_addr), .rb_addr(rb_addr), .eng_we(eng_we),
    .eng_waddr(eng_waddr), .eng_wdata(eng_wdata), .busy(busy), .done(done)
  );

  vec_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op_q), .a(ra_data), .b(rb_data), .acc(acc_q), .first(first),
    .elem_res(elem_res), .red_res(red_res)
  );

  vec_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(waddr), .wdata(wdata),
    .ra_addr(ra_addr), .rb_addr(rb_addr), .rh_addr(host_addr),
    .ra_data(ra_data), .rb_data(rb_data), .rh_data(host_rdata)
  );

  // R10
  eng_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> busy);
endmodule

// File: tb/vec_engine_bench.sv
module vec_engine_bench;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int MASK = (1 << DW) - 1;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start = 0;
  logic [2:0]    op_code = 0;
  logic [AW-1:0] src1_base = 0, src2_base = 0, dst_base = 0;
  logic [AW:0]   vec_len = 0;
  logic          busy, done;
  logic          host_we = 0;
  logic [AW-1:0] host_addr = 0;
  logic [DW-1:0] host_wdata = 0;
  logic [DW-1:0] host_rdata;

  int errors = 0;
  int checks = 0;
  int mm [DEPTH];

  always #10 clk = ~clk;

  vec_engine #(.DATA_W(DW), .ADDR_W(AW)) u_vec_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
    .src1_base(src1_base), .src2_base(src2_base), .dst_base(dst_base),
    .vec_len(vec_len), .busy(busy), .done(done), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_elem(int op, int a, int b);
    if (op == 1) return (a * b) & MASK;
    if (op == 2) return a & b;
    if (op == 3) return (a >= b) ? a : b;
    if (op == 4) return (a > b) ? 1 : 0;
    return (a + b) & MASK;
  endfunction

  task automatic host_put(input int a, input int v);
    @(negedge clk);
    host_we = 1; host_addr = AW'(a); host_wdata = DW'(v);
    @(negedge clk);
    host_we = 0;
    mm[a] = v & MASK;
  endtask

  task automatic readback(input string tag);
    for (int a = 0; a < DEPTH; a++) begin
      host_addr = AW'(a);
      #1;
      chk(int'(host_rdata) == mm[a], tag, int'(host_rdata), mm[a]);
    end
  endtask

  task automatic run(input int op, input int s1, input int s2, input int d,
                     input int n, input string tag, input bit inject);
    bit red;
    int due;
    int acc;
    red = (op == 5) || (op == 6);
    due = (n == 0) ? 0 : (red ? n + 1 : n);
    if (n > 0) begin
      if (red) begin
        acc = 0;
        for (int i = 0; i < n; i++) begin
          if (i == 0) acc = mm[(s1 + i) % DEPTH];
          else if (op == 5) acc = (acc + mm[(s1 + i) % DEPTH]) & MASK;
          else if (mm[(s1 + i) % DEPTH] > acc) acc = mm[(s1 + i) % DEPTH];
        end
        mm[d % DEPTH] = acc;
      end else begin
        for (int i = 0; i < n; i++) begin
          int b;
          b = (op == 7) ? mm[s2 % DEPTH] : mm[(s2 + i) % DEPTH];
          mm[(d + i) % DEPTH] = ref_elem(op, mm[(s1 + i) % DEPTH], b);
        end
      end
    end
    @(negedge clk);
    start = 1; op_code = 3'(op); src1_base = AW'(s1); src2_base = AW'(s2);
    dst_base = AW'(d); vec_len = (AW+1)'(n);
    for (int k = 0; k <= due; k++) begin
      @(negedge clk);
      start = 0; host_we = 0;
      chk(busy == 1'b1, tag, int'(busy), 1);
      chk(done == (k == due), tag, int'(done), int'(k == due));
      if (inject && k == 1 && due >= 3) begin
        // R2 / R10: stray start and host write while busy must be ignored
        start = 1; op_code = 3'd1; dst_base = AW'(10); vec_len = 7'd3;
        host_we = 1; host_addr = AW'(10); host_wdata = 16'hDEAD;
      end
    end
    @(negedge clk);
    start = 0; host_we = 0;
    chk(busy == 1'b0, "R2", int'(busy), 0);
    chk(done == 1'b0, "R3", int'(done), 0);
    if (inject) begin
      host_addr = AW'(10);
      #1;
      chk(int'(host_rdata) == mm[10], "R10", int'(host_rdata), mm[10]);
    end
    readback(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(busy == 1'b0, "R1", int'(busy), 0);
    chk(done == 1'b0, "R1", int'(done), 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", int'({busy, done}), 0);

    for (int a = 0; a < DEPTH; a++) host_put(a, (a * 2654435 + 97) & MASK);
    // vector A at 0..7, vector B at 16..23, with equal pairs and large values
    host_put(0, 5);      host_put(16, 3);
    host_put(1, 7);      host_put(17, 7);
    host_put(2, 16'hFF00); host_put(18, 16'h0300);
    host_put(3, 2);      host_put(19, 9);
    host_put(4, 16'h8001); host_put(20, 4);
    host_put(5, 0);      host_put(21, 0);
    host_put(6, 16'hFFFF); host_put(22, 1);
    host_put(7, 1234);   host_put(23, 1233);
    readback("R10");

    run(0, 0, 16, 32, 8, "R4", 1'b1);
    run(1, 0, 16, 40, 5, "R4", 1'b0);
    run(2, 0, 16, 48, 8, "R5", 1'b0);
    run(3, 0, 16, 32, 6, "R5", 1'b0);
    run(4, 0, 16, 56, 8, "R6", 1'b0);
    run(5, 0, 16, 60, 8, "R7", 1'b0);
    run(6, 0, 16, 61, 8, "R7", 1'b0);
    run(7, 0, 20, 44, 4, "R8", 1'b0);
    run(0, 0, 16, 0, 0, "R9", 1'b0);
    run(6, 2, 16, 3, 0, "R9", 1'b0);
    // R11: destination overlaps next source element; addresses wrap
    run(0, 32, 16, 33, 4, "R11", 1'b0);
    run(0, 62, 16, 60, 4, "R11", 1'b0);
    run(5, 61, 0, 30, 5, "R11", 1'b0);
    // R2: start accepted again right after completion
    run(3, 16, 0, 24, 3, "R2", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule